// File: doc/BRIEF.md
# Eight-Level Interrupt Controller Core

This block collects up to eight interrupt request lines, records each request, and signals the processor on a single interrupt line whenever a request is pending and not masked. It holds three per-level registers: pending requests, levels in service, and a mask. A request line is first passed through a two-flop synchronizer. A shared mode input then selects how requests are recorded: on the rising edge of the line, or for as long as the line is high.

The processor answers the interrupt with two acknowledge pulses on one input. The first pulse freezes the choice of which level wins. The second pulse marks that level as in service, removes its request, and puts out an 8-bit vector with a one-cycle valid strobe. The upper bits of the vector come from a programmed base register and the low three bits are the level number. Priority is fixed, with level 0 the highest. A level that is in service blocks itself and every lower-priority level until an end-of-interrupt pulse retires it. If nothing is serviceable at the first pulse, the second pulse returns the level-7 code and changes nothing.

Top module: `irq_ctrl_core`

## Requirements
- R1: In edge mode (`level_mode_i` = 0), a request for a level is recorded only when its line goes from low to high. A line held high after its request was acknowledged records no new request.
- R2: In level mode (`level_mode_i` = 1), the request for a level is present while its line is high and disappears once the line is low.
- R3: A request is recorded even while its mask bit is 1. A masked request neither raises `intr_o` nor wins an acknowledge. The whole mask is replaced by `mask_wdata_i` (bit i = level i, 1 = masked) in the cycle `mask_we_i` is high.
- R4: `intr_o` is high exactly when some recorded request has its mask bit clear. After an unmasked line rises, `intr_o` goes high at the third rising clock edge.
- R5: The first acknowledge pulse fixes the winning level. A request recorded between the first and second pulses does not change the vector returned by the second pulse.
- R6: Each cycle with `inta_i` high is one pulse, and the pulses alternate between first and second. `vec_valid_o` is high for exactly one cycle, following the clock edge that samples a second pulse.
- R7: When a level wins, the second pulse sets its in-service bit and clears its request bit.
- R8: `vec_o[7:3]` equals bits [7:3] of the base register, which is written from `base_wdata_i` when `base_we_i` is high. Base bits [2:0] are ignored. `vec_o[2:0]` is the winning level number, with level 0 giving 000 and level 7 giving 111.
- R9: Priority is fixed, with level 0 the highest. A request is serviceable only when no in-service bit at its own level or at a higher-priority level is set.
- R10: A one-cycle `eoi_i` pulse clears the highest-priority in-service bit that is set.
- R11: If no request is serviceable at the first pulse, the second pulse returns the level-7 code, sets no in-service bit, and leaves every request bit unchanged.
- R12: Reset clears the request and in-service bits, sets every mask bit, clears the base register, and holds `intr_o` and `vec_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Request lines, bit i = level i |
| level_mode_i | input | 1 | 0 = edge-triggered, 1 = level-triggered |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | New mask, 1 = level masked |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 8 | New base value; bits [2:0] are ignored |
| inta_i | input | 1 | Acknowledge pulse, one cycle high per pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector returned on the second pulse |
| vec_valid_o | output | 1 | One-cycle strobe marking `vec_o` valid |

## Verification
A rising request line reaches `intr_o` at the third clock edge: two synchronizer flops, then the request register. The bench drives at falling edges, so it samples three falling edges later, and it also checks that `intr_o` is still low one falling edge earlier. A mask or end-of-interrupt write takes effect at the next rising edge, so it is checked at the falling edge that follows. The vector strobe is high for the cycle after the edge that samples the second pulse. The driver queues the expected vector before raising that pulse, and the monitor compares it at the next falling edge. The monitor also rejects any strobe that lasts two cycles or arrives with nothing queued.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // Acknowledge handshake phase: waiting for first pulse, or armed for second.
   typedef enum logic {
      ACK_IDLE  = 1'b0,
      ACK_ARMED = 1'b1
   } ack_phase_e;
endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchronizer for asynchronous request lines.
module irq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_req_reg.sv
// Request register: edge or level capture of synchronized lines.
module irq_req_reg #(
   parameter int N_LEVELS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_LEVELS-1:0] line_i,
   input  logic                level_mode_i,
   input  logic [N_LEVELS-1:0] ack_clr_i,
   output logic [N_LEVELS-1:0] req_o
);
   logic [N_LEVELS-1:0] prev_q;
   logic [N_LEVELS-1:0] req_q;
   logic [N_LEVELS-1:0] rise;
   logic [N_LEVELS-1:0] req_d;

   assign rise = line_i & ~prev_q;

   always_comb begin
      if (level_mode_i) req_d = line_i & ~ack_clr_i;
      else              req_d = (req_q | rise) & ~ack_clr_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         req_q  <= '0;
      end else begin
         prev_q <= line_i;
         req_q  <= req_d;
      end
   end

   assign req_o = req_q;
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: lowest index wins.
module irq_prio_pick #(
   parameter int N_LEVELS = 8,
   localparam int IDX_W   = $clog2(N_LEVELS)
) (
   input  logic [N_LEVELS-1:0] req_i,
   output logic                any_o,
   output logic [IDX_W-1:0]    idx_o,
   output logic [N_LEVELS-1:0] onehot_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N_LEVELS - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o    = |req_i;
   assign onehot_o = req_i & (~req_i + 1'b1);
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
   import irq_pkg::*;
#(
   parameter int N_LEVELS    = 8,
   parameter int VEC_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int LVL_W      = $clog2(N_LEVELS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_LEVELS-1:0] irq_i,
   input  logic                level_mode_i,
   input  logic                mask_we_i,
   input  logic [N_LEVELS-1:0] mask_wdata_i,
   input  logic                base_we_i,
   input  logic [VEC_W-1:0]    base_wdata_i,
   input  logic                inta_i,
   input  logic                eoi_i,
   output logic                intr_o,
   output logic [VEC_W-1:0]    vec_o,
   output logic                vec_valid_o
);
   // Elaboration-time parameter checks
   if (N_LEVELS != (1 << LVL_W)) begin : g_bad_levels
      $error("N_LEVELS must be a power of two");
   end
   if (VEC_W <= LVL_W) begin : g_bad_vec
      $error("VEC_W must exceed the level index width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [N_LEVELS-1:0] line_s;
   logic [N_LEVELS-1:0] irr_q;
   logic [N_LEVELS-1:0] imr_q;
   logic [N_LEVELS-1:0] isr_q;
   logic [VEC_W-1:0]    base_q;
   logic [N_LEVELS-1:0] blocked;
   logic [N_LEVELS-1:0] cand;
   logic                cand_any;
   logic [LVL_W-1:0]    cand_idx;
   logic [N_LEVELS-1:0] cand_oh;
   logic                isr_any;
   logic [LVL_W-1:0]    isr_idx;
   logic [N_LEVELS-1:0] isr_oh;
   ack_phase_e          phase_q;
   logic [LVL_W-1:0]    win_idx_q;
   logic                win_ok_q;
   logic                ack_fire;
   logic [N_LEVELS-1:0] ack_clr;
   logic [N_LEVELS-1:0] eoi_clr;
   logic [VEC_W-1:0]    vec_q;
   logic                vld_q;

   irq_sync #(.WIDTH(N_LEVELS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (irq_i),
      .q_o   (line_s)
   );

   irq_req_reg #(.N_LEVELS(N_LEVELS)) u_req (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_i       (line_s),
      .level_mode_i (level_mode_i),
      .ack_clr_i    (ack_clr),
      .req_o        (irr_q)
   );

   // A level is blocked by any in-service bit at its own or higher priority.
   always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < N_LEVELS; i++) begin
         acc        = acc | isr_q[i];
         blocked[i] = acc;
      end
   end

   assign cand = irr_q & ~imr_q & ~blocked;

   irq_prio_pick #(.N_LEVELS(N_LEVELS)) u_pick_req (
      .req_i    (cand),
      .any_o    (cand_any),
      .idx_o    (cand_idx),
      .onehot_o (cand_oh)
   );

   irq_prio_pick #(.N_LEVELS(N_LEVELS)) u_pick_isr (
      .req_i    (isr_q),
      .any_o    (isr_any),
      .idx_o    (isr_idx),
      .onehot_o (isr_oh)
   );

   assign ack_fire = inta_i && (phase_q == ACK_ARMED);
   assign ack_clr  = (ack_fire && win_ok_q) ? (N_LEVELS'(1) << win_idx_q) : '0;
   assign eoi_clr  = (eoi_i && isr_any) ? isr_oh : '0;

   // Programmable mask and base registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr_q  <= '1;
         base_q <= '0;
      end else begin
         if (mask_we_i) imr_q  <= mask_wdata_i;
         if (base_we_i) base_q <= base_wdata_i;
      end
   end

   // Acknowledge handshake and in-service tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= ACK_IDLE;
         win_idx_q <= '0;
         win_ok_q  <= 1'b0;
         isr_q     <= '0;
         vec_q     <= '0;
         vld_q     <= 1'b0;
      end else begin
         isr_q <= (isr_q & ~eoi_clr) | ack_clr;
         vld_q <= ack_fire;
         if (inta_i) begin
            if (phase_q == ACK_IDLE) begin
               phase_q   <= ACK_ARMED;
               win_idx_q <= cand_idx;
               win_ok_q  <= cand_any;
            end else begin
               phase_q <= ACK_IDLE;
               vec_q   <= {base_q[VEC_W-1:LVL_W],
                           win_ok_q ? win_idx_q : {LVL_W{1'b1}}};
            end
         end
      end
   end

   assign intr_o      = |(irr_q & ~imr_q);
   assign vec_o       = vec_q;
   assign vec_valid_o = vld_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int N_LEVELS = 8,
   parameter int VEC_W    = 8,
   localparam int LVL_W   = $clog2(N_LEVELS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                inta_i,
   input logic                eoi_i,
   input logic                mask_we_i,
   input logic [N_LEVELS-1:0] mask_wdata_i,
   input logic                intr_o,
   input logic [VEC_W-1:0]    vec_o,
   input logic                vec_valid_o,
   input logic [N_LEVELS-1:0] isr_q,
   input logic [VEC_W-1:0]    base_q
);
   logic [N_LEVELS-1:0] prev_isr;
   logic [N_LEVELS-1:0] new_bits;
   logic [N_LEVELS-1:0] prev_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_isr <= '0;
      else        prev_isr <= isr_q;
   end

   assign new_bits = isr_q & ~prev_isr;
   assign prev_low = prev_isr & (~prev_isr + 1'b1);

   AST_MASKALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we_i && (&mask_wdata_i)) |=> !intr_o); // R3

   AST_VALID_FROM_INTA: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> $past(inta_i)); // R6

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |=> !vec_valid_o); // R6

   AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> (vec_o[VEC_W-1:LVL_W] == $past(base_q[VEC_W-1:LVL_W]))); // R8

   AST_ISR_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (new_bits != '0) |-> (vec_valid_o &&
         (new_bits == (N_LEVELS'(1) << vec_o[LVL_W-1:0])))); // R7

   AST_NEST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ((new_bits != '0) && (prev_isr != '0)) |-> (new_bits < prev_low)); // R9

   AST_EOI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_i && !inta_i && (isr_q != '0)) |=>
         ($countones(isr_q) == $countones(prev_isr) - 1)); // R10
endmodule

bind irq_ctrl_core irq_ctrl_chk #(.N_LEVELS(N_LEVELS), .VEC_W(VEC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .inta_i       (inta_i),
   .eoi_i        (eoi_i),
   .mask_we_i    (mask_we_i),
   .mask_wdata_i (mask_wdata_i),
   .intr_o       (intr_o),
   .vec_o        (vec_o),
   .vec_valid_o  (vec_valid_o),
   .isr_q        (isr_q),
   .base_q       (base_q)
);

// File: tb/tb_irq_ctrl_core.sv
module tb_irq_ctrl_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq = '0;
   logic       level_mode = 1'b0;
   logic       mask_we = 1'b0;
   logic [7:0] mask_wdata = '0;
   logic       base_we = 1'b0;
   logic [7:0] base_wdata = '0;
   logic       inta = 1'b0;
   logic       eoi = 1'b0;
   logic       intr;
   logic [7:0] vec;
   logic       vec_valid;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       prev_valid = 1'b0;

   always #2.5 clk = ~clk;

   irq_ctrl_core dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_i        (irq),
      .level_mode_i (level_mode),
      .mask_we_i    (mask_we),
      .mask_wdata_i (mask_wdata),
      .base_we_i    (base_we),
      .base_wdata_i (base_wdata),
      .inta_i       (inta),
      .eoi_i        (eoi),
      .intr_o       (intr),
      .vec_o        (vec),
      .vec_valid_o  (vec_valid)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Monitor: pop the expected vector when the strobe appears.
   always @(negedge clk) begin
      if (rst_n) begin
         if (vec_valid && prev_valid)
            check(1'b0, "R6 strobe longer than one cycle", 1, 0);
         if (vec_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected vector", vec, 0);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(vec == e, t, vec, e);
            end
         end
      end
      prev_valid <= vec_valid;
   end

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   // Driver: two pulses, expected vector queued before the second.
   task automatic ack(input logic [7:0] exp, input string tag);
      @(negedge clk); inta = 1'b1;
      @(negedge clk); inta = 1'b0;
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      inta = 1'b1;
      @(negedge clk); inta = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_eoi();
      @(negedge clk); eoi = 1'b1;
      @(negedge clk); eoi = 1'b0;
   endtask

   task automatic set_mask(input logic [7:0] m);
      @(negedge clk); mask_we = 1'b1; mask_wdata = m;
      @(negedge clk); mask_we = 1'b0;
   endtask

   task automatic set_base(input logic [7:0] b);
      @(negedge clk); base_we = 1'b1; base_wdata = b;
      @(negedge clk); base_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(intr == 1'b0, "R12 intr in reset", intr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(intr == 1'b0 && vec_valid == 1'b0, "R12 outputs after reset", {intr, vec_valid}, 0);

      // Masked at reset: request recorded but silent
      irq = 8'h08; settle();
      check(intr == 1'b0, "R12/R3 all masked after reset", intr, 0);
      set_mask(8'h00);
      check(intr == 1'b1, "R3 request recorded while masked", intr, 1);

      // Base low bits ignored, vector format
      set_base(8'h47);
      ack(8'h43, "R8 vector for level 3");
      check(intr == 1'b0, "R7 request cleared on ack", intr, 0);
      ack(8'h47, "R1 held line gives no new request (spurious)");

      // New edge on level 3 while in service: blocked
      irq = 8'h00; settle();
      irq = 8'h08; settle();
      check(intr == 1'b1, "R1 new rising edge recorded", intr, 1);
      ack(8'h47, "R9 same level blocked by in-service");
      check(intr == 1'b1, "R11 spurious leaves request", intr, 1);
      do_eoi();
      ack(8'h43, "R10 eoi releases level 3");
      do_eoi();
      irq = 8'h00; settle();

      // Fixed priority and nesting
      irq = 8'h24; settle();
      ack(8'h42, "R9 level 2 beats level 5");
      ack(8'h47, "R9 lower level blocked by in-service");
      do_eoi();
      ack(8'h45, "R9 level 5 after eoi");
      irq = 8'h26; settle();
      ack(8'h41, "R9 higher level nests");
      do_eoi();
      irq = 8'h00; settle();
      irq = 8'h04; settle();
      ack(8'h42, "R10 eoi cleared highest in-service bit");
      do_eoi(); do_eoi();
      irq = 8'h00; settle();
      irq = 8'h40; settle();
      ack(8'h46, "R10 all in-service cleared");
      do_eoi();
      irq = 8'h00; settle();

      // Freeze at first pulse
      @(negedge clk); inta = 1'b1; irq = 8'h40;
      @(negedge clk); inta = 1'b0;
      repeat (4) @(negedge clk);
      check(intr == 1'b1, "R5 request pending between pulses", intr, 1);
      exp_q.push_back(8'h47); tag_q.push_back("R5 frozen result is spurious");
      inta = 1'b1;
      @(negedge clk); inta = 1'b0;
      @(negedge clk);
      ack(8'h46, "R11 spurious set no in-service bit");
      do_eoi();
      irq = 8'h00; settle();

      // INTR latency
      @(negedge clk); irq = 8'h10;
      @(negedge clk);
      @(negedge clk);
      check(intr == 1'b0, "R4 intr not before third edge", intr, 0);
      @(negedge clk);
      check(intr == 1'b1, "R4 intr at third edge", intr, 1);
      ack(8'h44, "R4 vector level 4");
      do_eoi();
      irq = 8'h00; settle();

      // Mask a single level
      set_mask(8'h02);
      irq = 8'h02; settle();
      check(intr == 1'b0, "R3 masked level silent", intr, 0);
      ack(8'h47, "R3 masked level cannot win");
      set_mask(8'h00);
      check(intr == 1'b1, "R3 unmasked pending raises intr", intr, 1);
      ack(8'h41, "R3 vector after unmask");
      do_eoi();
      irq = 8'h00; settle();

      // Level mode
      level_mode = 1'b1;
      set_base(8'hAD);
      irq = 8'h01; settle();
      check(intr == 1'b1, "R2 high line requests", intr, 1);
      ack(8'hA8, "R8 new base, level 0");
      do_eoi();
      settle();
      check(intr == 1'b1, "R2 held line keeps request", intr, 1);
      irq = 8'h00; settle();
      check(intr == 1'b0, "R2 request drops with line", intr, 0);

      settle();
      check(exp_q.size() == 0, "R6 every queued vector produced", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule